// File: doc/BRIEF.md
# Card Clock Divider with Bypass

This block produces the clock that drives a memory-card bus from the faster master clock of the host controller. A control word carries an 8-bit divide value, an enable flag and a bypass flag. When divided mode is running, the output is a square wave with an exact 50 % duty cycle. The block also emits two single-cycle strobes in the master clock domain. One marks each rising edge of the card clock and the other marks each falling edge. The command and data shifters use these strobes to launch and capture bits without crossing a clock domain. When the bypass flag is set, the master clock itself is forwarded and the divide value has no effect.

The block is a four-state machine. CK_OFF holds the output low. CK_LOW and CK_HIGH are the two half-periods of divided mode. CK_PASS forwards the master clock. The transitions are:

- CK_OFF to CK_LOW when enabled without bypass.
- CK_OFF to CK_PASS when enabled with bypass.
- CK_LOW to CK_HIGH and CK_HIGH to CK_LOW when the phase counter reaches the latched divide value.
- Any state to CK_OFF when enable drops.
- CK_LOW or CK_HIGH to CK_PASS when bypass rises.
- CK_PASS to CK_OFF when bypass or enable drops. Divided mode then restarts from CK_OFF on the next cycle.

Top module: `ccd_card_clock`

## Requirements
- R1: During reset and after it while enable is clear, the card clock, the rise strobe and the fall strobe are all low.
- R2: With enable (control bit 8) set and bypass (control bit 10) clear, the card clock stays high for N+1 master cycles and low for N+1 master cycles, giving a period of 2*(N+1), where N is control bits [7:0].
- R3: N = 255 gives the slowest rate: 256 cycles high and 256 cycles low.
- R4: N = 0 gives the fastest divided rate: one cycle high and one cycle low.
- R5: When enable (bit 8) is clear, the card clock is low and both strobes are low from the master cycle after the write, whatever the divide and bypass bits hold.
- R6: With enable and bypass both set, the card clock follows the master clock, the rise strobe is high every master cycle and the fall strobe is low; the divide bits have no effect. Clearing bypass while enable stays set restarts divided mode through one CK_OFF cycle, so the first rise strobe appears N+3 cycles after the write.
- R7: The rise strobe is high for exactly the first master cycle of each high half-period, and the fall strobe for exactly the first master cycle of each low half-period that follows a high one.
- R8: A new divide value written while the clock runs does not shorten or stretch the half-period in progress; it first governs the half-period after the next counter reload.
- R9: After enable is set from CK_OFF, the card clock stays low for N+1 cycles, so the first rise strobe is seen N+2 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 11 | Control word: [7:0] divide value, [8] enable, [10] bypass, [9] unused |
| card_clk_o | output | 1 | Card clock |
| rise_tick_o | output | 1 | One-cycle strobe in the first cycle of each high phase; constant high in bypass |
| fall_tick_o | output | 1 | One-cycle strobe in the first cycle of each low phase |

## Verification
The hardest case to reach is a divide-value change that lands in the middle of a half-period. The latched limit must keep the current phase at its old length and switch only at the reload. The bench writes the new value in the very cycle the rise strobe appears. It then measures that high phase at the old length, followed by low and high phases at the new length. A second hard case is the exit from bypass back to divided mode. This path passes through one CK_OFF cycle, and the bench checks for it by timing the first rise strobe after bypass is cleared.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    typedef enum logic [1:0] {
        CK_OFF  = 2'd0,
        CK_LOW  = 2'd1,
        CK_HIGH = 2'd2,
        CK_PASS = 2'd3
    } ck_state_e;

endpackage

// File: rtl/ccd_field_decode.sv
module ccd_field_decode #(
    parameter int DIV_W   = 8,
    parameter int CTRL_W  = 11,
    parameter int EN_POS  = 8,
    parameter int BYP_POS = 10
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [DIV_W-1:0]  div_o,
    output logic              en_o,
    output logic              byp_o
);

    // Bits outside the three fields are reserved and read as don't-care.
    logic unused_rest;
    assign unused_rest = ^ctrl_i;

    assign div_o = ctrl_i[DIV_W-1:0];
    assign en_o  = ctrl_i[EN_POS];
    assign byp_o = ctrl_i[BYP_POS];

endmodule

// File: rtl/ccd_phase_counter.sv
module ccd_phase_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] lim_i,
    output logic         term_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;
    logic         at_lim;

    assign at_lim = (cnt_q == lim_q);
    assign term_o = run_i && at_lim;

    // The limit is captured only while idle or at a reload.
    // This keeps a half-period from being cut short or stretched.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
            lim_q <= lim_i;
        end else if (at_lim) begin
            cnt_q <= '0;
            lim_q <= lim_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: limit changes only at a reload while running
    a_r8_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !at_lim) |=> (lim_q == $past(lim_q)));

    // R2: the count never passes the latched limit
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= lim_q));

    // R2: a terminal count reloads to zero
    a_r2_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |=> (cnt_q == '0));

endmodule

// File: rtl/ccd_card_clock.sv
module ccd_card_clock
    import ccd_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int EN_POS  = 8,
    parameter int BYP_POS = 10,
    parameter int CTRL_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              card_clk_o,
    output logic              rise_tick_o,
    output logic              fall_tick_o
);

    logic [DIV_W-1:0] div_w;
    logic             en_w;
    logic             byp_w;
    logic             run_w;
    logic             term_w;
    logic             rise_q;
    logic             fall_q;
    logic             div_high;
    ck_state_e        state_q;
    ck_state_e        state_nx;

    ccd_field_decode #(
        .DIV_W  (DIV_W),
        .CTRL_W (CTRL_W),
        .EN_POS (EN_POS),
        .BYP_POS(BYP_POS)
    ) u_decode (
        .ctrl_i(ctrl_i),
        .div_o (div_w),
        .en_o  (en_w),
        .byp_o (byp_w)
    );

    assign run_w = (state_q == CK_LOW) || (state_q == CK_HIGH);

    ccd_phase_counter #(
        .W(DIV_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run_w),
        .lim_i (div_w),
        .term_o(term_w)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CK_OFF: begin
                if (en_w) state_nx = byp_w ? CK_PASS : CK_LOW;
            end
            CK_LOW: begin
                if (!en_w)      state_nx = CK_OFF;
                else if (byp_w) state_nx = CK_PASS;
                else if (term_w) state_nx = CK_HIGH;
            end
            CK_HIGH: begin
                if (!en_w)      state_nx = CK_OFF;
                else if (byp_w) state_nx = CK_PASS;
                else if (term_w) state_nx = CK_LOW;
            end
            CK_PASS: begin
                if (!en_w || !byp_w) state_nx = CK_OFF;
            end
            default: state_nx = CK_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CK_OFF;
        else        state_q <= state_nx;
    end

    // Edge strobes, registered together with the state they mark
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= (state_q == CK_LOW)  && (state_nx == CK_HIGH);
            fall_q <= (state_q == CK_HIGH) && (state_nx == CK_LOW);
        end
    end

    assign div_high = (state_q == CK_HIGH);

    always_comb begin
        card_clk_o  = (state_q == CK_PASS) ? clk : div_high;
        rise_tick_o = rise_q || (state_q == CK_PASS);
        fall_tick_o = fall_q;
    end

    // R5: enable clear silences the clock and strobes one cycle later
    a_r5_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i[EN_POS] |=> (!div_high && !rise_tick_o && !fall_tick_o));

    // R6: bypass with enable gives a rise strobe every cycle, no fall strobe
    a_r6_bypass_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[EN_POS] && ctrl_i[BYP_POS]) |=> (rise_tick_o && !fall_tick_o));

    // R7: divided rise strobe lasts one cycle
    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |=> !rise_q);

    // R7: the two strobes never coincide
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_tick_o, fall_tick_o}));

endmodule

// File: tb/ccd_card_clock_bench.sv
module ccd_card_clock_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ctrl = '0;
    logic        card_clk;
    logic        rise_tick;
    logic        fall_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    localparam int WATCHDOG = 150000;

    always #10 clk = ~clk;

    ccd_card_clock u_ccd_card_clock (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .card_clk_o (card_clk),
        .rise_tick_o(rise_tick),
        .fall_tick_o(fall_tick)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [10:0] mk(input bit en, input bit byp, input int n);
        logic [10:0] v;
        v = '0;
        v[7:0] = n[7:0];
        v[8] = en;
        v[10] = byp;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go_off();
        @(negedge clk);
        ctrl = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rise_tick && n < 3000);
    endtask

    // Called at the negedge where a rise strobe was seen.
    task automatic measure(output int h, output int l, output bit bad);
        bad = (card_clk !== 1'b1);
        h = 1;
        forever begin
            @(negedge clk);
            if (fall_tick || h > 3000) break;
            if (card_clk !== 1'b1 || rise_tick) bad = 1;
            h++;
        end
        l = 1;
        if (card_clk !== 1'b0) bad = 1;
        forever begin
            @(negedge clk);
            if (rise_tick || l > 3000) break;
            if (card_clk !== 1'b0 || fall_tick) bad = 1;
            l++;
        end
    endtask

    task automatic t_reset();
        chk(card_clk === 1'b0 && rise_tick === 1'b0 && fall_tick === 1'b0,
            "R1 outputs in reset", int'(card_clk), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(card_clk === 1'b0 && rise_tick === 1'b0 && fall_tick === 1'b0,
            "R1 outputs idle after reset", int'({card_clk, rise_tick, fall_tick}), 0);
    endtask

    task automatic t_divide(input int n, input string req);
        int first, h, l;
        bit bad;
        go_off();
        ctrl = mk(1, 0, n);
        wait_rise(first);
        chk(first == n + 2, "R9 first rise delay", first, n + 2);
        measure(h, l, bad);
        chk(h == n + 1, {req, " high length"}, h, n + 1);
        chk(l == n + 1, {req, " low length"}, l, n + 1);
        chk(!bad, "R7 strobe and level shape", int'(bad), 0);
        measure(h, l, bad);
        chk(h + l == 2 * (n + 1), {req, " period"}, h + l, 2 * (n + 1));
    endtask

    task automatic t_bypass();
        bit ok_neg, ok_pos;
        int first;
        go_off();
        ctrl = mk(1, 1, 7);
        @(negedge clk);
        ok_neg = 1;
        ok_pos = 1;
        for (int i = 0; i < 8; i++) begin
            if (i == 4) ctrl = mk(1, 1, 200);   // divide bits must not matter
            @(posedge clk);
            #5;
            if (card_clk !== 1'b1) ok_pos = 0;
            @(negedge clk);
            if (card_clk !== 1'b0 || rise_tick !== 1'b1 || fall_tick !== 1'b0) ok_neg = 0;
        end
        chk(ok_pos, "R6 card clock high with master high", int'(ok_pos), 1);
        chk(ok_neg, "R6 low with master low, rise strobe every cycle", int'(ok_neg), 1);
        ctrl = mk(1, 0, 2);
        wait_rise(first);
        chk(first == 5, "R6 exit from bypass restart", first, 5);
    endtask

    task automatic t_disable();
        int first;
        bit ok;
        go_off();
        ctrl = mk(1, 0, 4);
        wait_rise(first);
        @(negedge clk);
        ctrl = mk(0, 1, 4);   // enable clear, other fields set
        ok = 1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            #5;
            if (card_clk !== 1'b0) ok = 0;
            @(negedge clk);
            if (card_clk !== 1'b0 || rise_tick !== 1'b0 || fall_tick !== 1'b0) ok = 0;
        end
        chk(ok, "R5 enable clear stops clock and strobes", int'(ok), 1);
    endtask

    task automatic t_change();
        int first, h, l;
        bit bad;
        go_off();
        ctrl = mk(1, 0, 3);
        wait_rise(first);
        ctrl = mk(1, 0, 6);   // written in the first cycle of a high phase
        measure(h, l, bad);
        chk(h == 4, "R8 current phase keeps old length", h, 4);
        chk(l == 7, "R8 next phase takes new value", l, 7);
        measure(h, l, bad);
        chk(h == 7 && l == 7, "R8 steady new rate", h * 100 + l, 707);
    endtask

    initial begin
        t_reset();
        t_divide(3, "R2");
        t_divide(10, "R2");
        t_divide(0, "R4");
        t_divide(255, "R3");
        t_bypass();
        t_disable();
        t_change();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule